// File: doc/BRIEF.md
# Dual-Chamber Pacing Controller

This block times and issues pacing pulses for two heart chambers, handled in strict alternation: first the upper chamber (atrium), then the lower chamber (ventricle). For each chamber the controller arms a private countdown. It then waits for that chamber's own sensed beat. If the beat arrives before the countdown runs out, no pulse is issued and control passes to the other chamber. If the countdown reaches zero with no beat, the controller issues a one-cycle pace pulse for that chamber and then passes control on.

Both countdown timers are inside the block. Each reloads to `RELOAD_TICKS` clock ticks whenever the controller strobes its restart. The default value is 0.8 s at 250 MHz, and simulation uses a small count. Once a timer reaches zero, its expired flag stays high until the next restart. The restart strobes and the expired flags are brought out as ports so the surrounding logic can watch the timing. All outputs are decoded from the registered state alone. Reset is asynchronous and active low, and it places the controller in the atrial-arm step.

Top module: `dual_chamber_pacer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `atrial_restart` is 1 and `atrial_pace`, `vent_pace` and `vent_restart` are 0.
- R2: After an `atrial_restart` cycle, `atrial_expired` is 0 for the next `RELOAD_TICKS` cycles. It is 1 in cycle `RELOAD_TICKS`+1 after the strobe and stays 1 until the next `atrial_restart`.
- R3: If `atrial_sense` is 1 in any atrial waiting cycle, including the cycle in which `atrial_expired` is 1, the next cycle has `vent_restart`=1, and no `atrial_pace` is issued for that beat.
- R4: If no `atrial_sense` arrives while waiting, `atrial_pace` is 1 for exactly one cycle, in the cycle after `atrial_expired` first reads 1. `vent_restart` is 1 in the cycle that follows.
- R5: The ventricular timer behaves like R2, using `vent_restart` and `vent_expired`.
- R6: If `vent_sense` is 1 in any ventricular waiting cycle, including the expiry cycle, the next cycle has `atrial_restart`=1, and no `vent_pace` is issued.
- R7: If no `vent_sense` arrives while waiting, `vent_pace` is 1 for exactly one cycle, in the cycle after `vent_expired` first reads 1. `atrial_restart` is 1 in the cycle that follows.
- R8: A sense for the chamber that is not being waited on has no effect on any output.
- R9: At most one of `atrial_pace`, `vent_pace`, `atrial_restart` and `vent_restart` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| atrial_sense | input | 1 | Natural atrial beat detected |
| vent_sense | input | 1 | Natural ventricular beat detected |
| atrial_pace | output | 1 | One-cycle atrial pace pulse |
| vent_pace | output | 1 | One-cycle ventricular pace pulse |
| atrial_restart | output | 1 | Atrial timer reload strobe |
| vent_restart | output | 1 | Ventricular timer reload strobe |
| atrial_expired | output | 1 | Atrial countdown has reached zero |
| vent_expired | output | 1 | Ventricular countdown has reached zero |

## Verification
For each chamber, a single-cycle sense is swept across every waiting cycle, from the first cycle through the expiry cycle. Each sweep has one run with no sense at all. The sweep separates "sense in time" from "timeout", and the final swept position checks that a sense on the same cycle as expiry still wins. The run with no sense pins the exact cycle of the pace pulse, shows that it lasts one cycle, and checks where the expired flag rises and how long it holds. Throughout every wait, the other chamber's sense input is held high, which shows that it is ignored.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
   typedef enum logic [2:0] {
      ST_ARM_A  = 3'd0,
      ST_WAIT_A = 3'd1,
      ST_PACE_A = 3'd2,
      ST_ARM_V  = 3'd3,
      ST_WAIT_V = 3'd4,
      ST_PACE_V = 3'd5
   } pace_state_e;

   localparam int NUM_CHAMBERS = 2;
   localparam int CH_ATRIUM    = 0;
   localparam int CH_VENT      = 1;
endpackage

// File: rtl/pacer_timer.sv
module pacer_timer #(
   parameter int RELOAD_TICKS = 8,
   parameter bit COUNT_DOWN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic expired_o
);
   localparam int CNT_W = $clog2(RELOAD_TICKS + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(RELOAD_TICKS);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   generate
      if (RELOAD_TICKS < 1) begin : g_bad_reload
         $error("pacer_timer: RELOAD_TICKS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   generate
      if (COUNT_DOWN) begin : g_down
         // Loads the full count and runs down to zero, where it holds.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= LOAD;
            else if (restart_i)
               cnt_q <= LOAD;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - ONE;
         end
         assign expired_o = (cnt_q == '0);
      end else begin : g_up
         // Clears to zero and runs up to the reload value, where it holds.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (restart_i)
               cnt_q <= '0;
            else if (cnt_q != LOAD)
               cnt_q <= cnt_q + ONE;
         end
         assign expired_o = (cnt_q == LOAD);
      end
   endgenerate
endmodule

// File: rtl/pacer_fsm.sv
module pacer_fsm
   import pacer_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CHAMBERS-1:0] sense_i,
   input  logic [NUM_CHAMBERS-1:0] expired_i,
   output logic [NUM_CHAMBERS-1:0] pace_o,
   output logic [NUM_CHAMBERS-1:0] restart_o
);
   pace_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_ARM_A;
      else
         state_q <= state_d;
   end

   // A sense wins over a same-cycle expiry: it is tested first.
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_ARM_A:  state_d = ST_WAIT_A;
         ST_WAIT_A: begin
            if (sense_i[CH_ATRIUM])
               state_d = ST_ARM_V;
            else if (expired_i[CH_ATRIUM])
               state_d = ST_PACE_A;
         end
         ST_PACE_A: state_d = ST_ARM_V;
         ST_ARM_V:  state_d = ST_WAIT_V;
         ST_WAIT_V: begin
            if (sense_i[CH_VENT])
               state_d = ST_ARM_A;
            else if (expired_i[CH_VENT])
               state_d = ST_PACE_V;
         end
         ST_PACE_V: state_d = ST_ARM_A;
         default:   state_d = ST_ARM_A;
      endcase
   end

   // Moore outputs; everything not named in a state stays low.
   always_comb begin
      pace_o    = '0;
      restart_o = '0;
      pace_o[CH_ATRIUM]    = (state_q == ST_PACE_A);
      pace_o[CH_VENT]      = (state_q == ST_PACE_V);
      restart_o[CH_ATRIUM] = (state_q == ST_ARM_A);
      restart_o[CH_VENT]   = (state_q == ST_ARM_V);
   end
endmodule

// File: rtl/dual_chamber_pacer.sv
module dual_chamber_pacer
   import pacer_pkg::*;
#(
   parameter int RELOAD_TICKS = 200_000_000,
   parameter bit COUNT_DOWN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic atrial_sense,
   input  logic vent_sense,
   output logic atrial_pace,
   output logic vent_pace,
   output logic atrial_restart,
   output logic vent_restart,
   output logic atrial_expired,
   output logic vent_expired
);
   logic [NUM_CHAMBERS-1:0] sense_v, expired_v, pace_v, restart_v;

   assign sense_v[CH_ATRIUM] = atrial_sense;
   assign sense_v[CH_VENT]   = vent_sense;

   pacer_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sense_i   (sense_v),
      .expired_i (expired_v),
      .pace_o    (pace_v),
      .restart_o (restart_v)
   );

   generate
      for (genvar g = 0; g < NUM_CHAMBERS; g++) begin : g_chamber
         pacer_timer #(
            .RELOAD_TICKS (RELOAD_TICKS),
            .COUNT_DOWN   (COUNT_DOWN)
         ) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart_v[g]),
            .expired_o (expired_v[g])
         );
      end
   endgenerate

   assign atrial_pace    = pace_v[CH_ATRIUM];
   assign vent_pace      = pace_v[CH_VENT];
   assign atrial_restart = restart_v[CH_ATRIUM];
   assign vent_restart   = restart_v[CH_VENT];
   assign atrial_expired = expired_v[CH_ATRIUM];
   assign vent_expired   = expired_v[CH_VENT];
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker (
   input logic clk,
   input logic rst_n,
   input logic atrial_sense,
   input logic vent_sense,
   input logic atrial_pace,
   input logic vent_pace,
   input logic atrial_restart,
   input logic vent_restart,
   input logic atrial_expired,
   input logic vent_expired
);
   // R9: strobes and pulses never overlap
   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({atrial_pace, vent_pace, atrial_restart, vent_restart}));

   // R4: atrial pace lasts one cycle and hands over to the ventricle
   a_r4_apace_handover: assert property (@(posedge clk) disable iff (!rst_n)
      atrial_pace |=> (!atrial_pace && vent_restart));

   // R4: atrial pace only after an unsensed expiry
   a_r4_apace_cause: assert property (@(posedge clk) disable iff (!rst_n)
      atrial_pace |-> ($past(atrial_expired) && !$past(atrial_sense)));

   // R7: ventricular pace lasts one cycle and hands back to the atrium
   a_r7_vpace_handover: assert property (@(posedge clk) disable iff (!rst_n)
      vent_pace |=> (!vent_pace && atrial_restart));

   // R7: ventricular pace only after an unsensed expiry
   a_r7_vpace_cause: assert property (@(posedge clk) disable iff (!rst_n)
      vent_pace |-> ($past(vent_expired) && !$past(vent_sense)));

   // R2: restart clears the atrial expired flag
   a_r2_atimer_reload: assert property (@(posedge clk) disable iff (!rst_n)
      atrial_restart |=> !atrial_expired);

   // R5: restart clears the ventricular expired flag
   a_r5_vtimer_reload: assert property (@(posedge clk) disable iff (!rst_n)
      vent_restart |=> !vent_expired);
endmodule

bind dual_chamber_pacer pacer_checker u_chk (.*);

// File: tb/dual_chamber_pacer_test.sv
module dual_chamber_pacer_test;
   localparam int R = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic atrial_sense = 1'b0;
   logic vent_sense = 1'b0;
   logic atrial_pace, vent_pace, atrial_restart, vent_restart;
   logic atrial_expired, vent_expired;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_chamber_pacer #(.RELOAD_TICKS(R)) uut (
      .clk(clk), .rst_n(rst_n),
      .atrial_sense(atrial_sense), .vent_sense(vent_sense),
      .atrial_pace(atrial_pace), .vent_pace(vent_pace),
      .atrial_restart(atrial_restart), .vent_restart(vent_restart),
      .atrial_expired(atrial_expired), .vent_expired(vent_expired)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_strobes(input string req);
      int n1 = $countones({atrial_pace, vent_pace, atrial_restart, vent_restart});
      chk(n1 <= 1, req, n1, 1);
   endtask

   // Atrial sweep step: d in 0..R places one sense at waiting cycle d; d<0 means none.
   // The ventricular sense is held high throughout the wait (R8).
   task automatic atrial_trial(input int d);
      int last = (d < 0) ? R + 3 : d + 2;
      bit saw_pace = 1'b0;
      do @(negedge clk); while (!atrial_restart);
      for (int n = 1; n <= last; n++) begin
         @(negedge clk);
         chk_strobes("R9 atrial phase");
         if (n < last - ((d < 0) ? 1 : 0) && atrial_pace) saw_pace = 1'b1;
         if (d >= 0 && n == d + 2) begin
            chk(vent_restart == 1'b1, "R3 sensed atrial beat -> vent restart", vent_restart, 1);
            chk(!saw_pace && !atrial_pace, "R3 no atrial pace when sensed", saw_pace, 0);
         end
         if (d < 0) begin
            if (n == R)     chk(atrial_expired == 1'b0, "R2 atrial flag low before expiry", atrial_expired, 0);
            if (n == R + 1) chk(atrial_expired == 1'b1, "R2 atrial flag at expiry", atrial_expired, 1);
            if (n == R + 1) chk(vent_restart == 1'b0, "R8 vent sense ignored in atrial wait", vent_restart, 0);
            if (n == R + 2) begin
               chk(atrial_pace == 1'b1, "R4 atrial pace after timeout", atrial_pace, 1);
               chk(atrial_expired == 1'b1, "R2 atrial flag holds", atrial_expired, 1);
            end
            if (n == R + 3) begin
               chk(atrial_pace == 1'b0, "R4 atrial pace one cycle", atrial_pace, 0);
               chk(vent_restart == 1'b1, "R4 vent restart after atrial pace", vent_restart, 1);
            end
         end
         // drive for the next edge
         atrial_sense = (n - 1 == d);
         vent_sense   = (d < 0) ? (n <= R + 1) : (n <= d + 1);
         if (n == last) begin atrial_sense = 1'b0; vent_sense = 1'b0; end
      end
      atrial_sense = 1'b0;
      vent_sense   = 1'b0;
   endtask

   task automatic vent_trial(input int d);
      int last = (d < 0) ? R + 3 : d + 2;
      bit saw_pace = 1'b0;
      do @(negedge clk); while (!vent_restart);
      for (int n = 1; n <= last; n++) begin
         @(negedge clk);
         chk_strobes("R9 vent phase");
         if (n < last - ((d < 0) ? 1 : 0) && vent_pace) saw_pace = 1'b1;
         if (d >= 0 && n == d + 2) begin
            chk(atrial_restart == 1'b1, "R6 sensed vent beat -> atrial restart", atrial_restart, 1);
            chk(!saw_pace && !vent_pace, "R6 no vent pace when sensed", saw_pace, 0);
         end
         if (d < 0) begin
            if (n == R)     chk(vent_expired == 1'b0, "R5 vent flag low before expiry", vent_expired, 0);
            if (n == R + 1) chk(vent_expired == 1'b1, "R5 vent flag at expiry", vent_expired, 1);
            if (n == R + 1) chk(atrial_restart == 1'b0, "R8 atrial sense ignored in vent wait", atrial_restart, 0);
            if (n == R + 2) begin
               chk(vent_pace == 1'b1, "R7 vent pace after timeout", vent_pace, 1);
               chk(vent_expired == 1'b1, "R5 vent flag holds", vent_expired, 1);
            end
            if (n == R + 3) begin
               chk(vent_pace == 1'b0, "R7 vent pace one cycle", vent_pace, 0);
               chk(atrial_restart == 1'b1, "R7 atrial restart after vent pace", atrial_restart, 1);
            end
         end
         vent_sense   = (n - 1 == d);
         atrial_sense = (d < 0) ? (n <= R + 1) : (n <= d + 1);
         if (n == last) begin atrial_sense = 1'b0; vent_sense = 1'b0; end
      end
      atrial_sense = 1'b0;
      vent_sense   = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(atrial_restart == 1'b1, "R1 arm atrium in reset", atrial_restart, 1);
      chk(!atrial_pace && !vent_pace && !vent_restart, "R1 others low in reset",
          {atrial_pace, vent_pace, vent_restart}, 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(atrial_restart == 1'b0, "R1 leaves arm step after first edge", atrial_restart, 0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(atrial_restart == 1'b1, "R1 first cycle after release", atrial_restart, 1);
      for (int d = -1; d <= R; d++) atrial_trial(d);
      for (int d = -1; d <= R; d++) vent_trial(d);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule